// File: doc/BRIEF.md
# Decode-Stage Register Set

This block holds the architectural storage that a multicycle 16-bit processor's decode stage relies on. It has three parts. The first is an instruction register, loaded from the memory read data. The second is a three-flag condition register, which records the sign class of the last value written back. The third is an eight-entry, 16-bit register file with two combinational read ports and one write port. The controller's 4-bit state code gates every update. The instruction register loads only in the decode state. The flags and the register file change only in the register-update state.

The register addresses are taken from fields of the held instruction. The block returns a 48-bit bundle that carries the instruction and both operand values to the execute and memory stages. It also returns a 2-bit instruction class. This class is decoded straight from the memory read data, not from the instruction register. As a result the controller can branch on it during the decode state itself, the same cycle in which the instruction register is still loading.

Top module: `dec_regs`

## Requirements
- R1: On a rising clock edge with `state` equal to 4'h1 (decode), the instruction register takes `mem_dout`. In every other state it keeps its value.
- R2: `itype` follows `mem_dout[15:12]` combinationally, whatever the state and the held instruction. It is 0 for opcodes 0001, 0101 and 1001. It is 1 for 0000, 1100 and 0100. It is 2 for 0010, 0110, 1010, 1110, 0011, 0111 and 1011. It is 3 for 1000, 1101 and 1111.
- R3: On a rising edge with `state` equal to 4'h8 (register update), the register addressed by IR[11:9] takes `wb_data`. The other seven registers keep their values.
- R4: `data_bundle[47:32]` is the instruction register. `data_bundle[31:16]` is the register addressed by IR[8:6]. `data_bundle[15:0]` is the register chosen as second source.
- R5: The second source address is IR[2:0]. For the store opcodes 0011, 0111 and 1011 it is IR[11:9] instead.
- R6: On a register-update edge, `cond_flags` = {N,Z,P} is set from `wb_data`. Z is 1 when the value is zero. Otherwise N is 1 when bit 15 is set, and P is 1 in all other cases. Exactly one flag is 1.
- R7: When a register is read and written in the same cycle, the read port returns the old value. The new value appears after the edge.
- R8: A synchronous active-high `rst` clears the instruction register and all eight registers to zero and sets `cond_flags` to 3'b010.
- R9: Outside the register-update state, `wb_data` has no effect on the register file or on `cond_flags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| state | input | 4 | Controller state code |
| mem_dout | input | 16 | Memory read data |
| wb_data | input | 16 | Value to write into the register file |
| data_bundle | output | 48 | {instruction, first operand, second operand} |
| itype | output | 2 | Instruction class decoded from memory data |
| cond_flags | output | 3 | Condition flags {N,Z,P} |

## Verification
A wrongly captured instruction shows at once in `data_bundle[47:32]` at the sample point after the decode edge. It also shows one level further on, because wrong source addresses select the wrong operand values. A corrupted register, or one written in the wrong state, stays hidden until some later instruction names it as a source. For that reason the tests read back the targeted entry, and its neighbours, immediately after every write and after every blocked write. Flag faults are visible on `cond_flags` in the first sample after the update edge. The class code is checked within the same cycle in which the memory data changes.

// File: rtl/dec_regs_pkg.sv
package dec_regs_pkg;

    localparam int DATA_W   = 16;
    localparam int NUM_REGS = 8;
    localparam int RADDR_W  = $clog2(NUM_REGS);
    localparam int STATE_W  = 4;
    localparam int OPC_LSB  = DATA_W - 4;

    localparam logic [STATE_W-1:0] ST_DECODE    = 4'h1;
    localparam logic [STATE_W-1:0] ST_REG_WRITE = 4'h8;

    typedef enum logic [1:0] {
        CLS_ARITH = 2'd0,
        CLS_FLOW  = 2'd1,
        CLS_MEM   = 2'd2,
        CLS_NONE  = 2'd3
    } instr_cls_e;

    typedef struct packed {
        logic neg;
        logic zer;
        logic pos;
    } flags_t;

    typedef struct packed {
        logic [RADDR_W-1:0] dst;
        logic [RADDR_W-1:0] src_a;
        logic [RADDR_W-1:0] src_b;
    } reg_sel_t;

    function automatic instr_cls_e classify(input logic [3:0] opc);
        case (opc)
            4'b0001, 4'b0101, 4'b1001:                  return CLS_ARITH;
            4'b0000, 4'b1100, 4'b0100:                  return CLS_FLOW;
            4'b0010, 4'b0110, 4'b1010, 4'b1110,
            4'b0011, 4'b0111, 4'b1011:                  return CLS_MEM;
            default:                                    return CLS_NONE;
        endcase
    endfunction

    function automatic logic is_store(input logic [3:0] opc);
        return (opc == 4'b0011) || (opc == 4'b0111) || (opc == 4'b1011);
    endfunction

    function automatic flags_t sign_class(input logic [DATA_W-1:0] v);
        flags_t f;
        f.zer = (v == '0);
        f.neg = !f.zer && v[DATA_W-1];
        f.pos = !f.zer && !v[DATA_W-1];
        return f;
    endfunction

endpackage

// File: rtl/dec_instr_reg.sv
module dec_instr_reg
    import dec_regs_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] ir,
    output reg_sel_t     sel
);
    localparam int OPC = W - 4;

    always_ff @(posedge clk) begin
        if (rst)       ir <= '0;
        else if (load) ir <= din;
    end

    always_comb begin
        sel.dst   = ir[11:9];
        sel.src_a = ir[8:6];
        sel.src_b = is_store(ir[W-1:OPC]) ? ir[11:9] : ir[2:0];
    end

    assert_ir_load_R1: assert property (@(posedge clk) disable iff (rst)
        load |=> ir == $past(din));
    assert_ir_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(ir));
endmodule

// File: rtl/dec_flag_reg.sv
module dec_flag_reg
    import dec_regs_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         upd,
    input  logic [W-1:0] val,
    output flags_t       flags
);
    always_ff @(posedge clk) begin
        if (rst)      flags <= '{neg: 1'b0, zer: 1'b1, pos: 1'b0};
        else if (upd) flags <= sign_class(val);
    end

    assert_flags_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        $countones(flags) == 1);
    assert_flags_zero_R6: assert property (@(posedge clk) disable iff (rst)
        upd && (val == '0) |=> flags.zer);
    assert_flags_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(flags));
endmodule

// File: rtl/dec_regfile.sv
module dec_regfile
    import dec_regs_pkg::*;
#(
    parameter int W = DATA_W,
    parameter int N = NUM_REGS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [$clog2(N)-1:0] waddr,
    input  logic [W-1:0]         wdata,
    input  logic [$clog2(N)-1:0] raddr_a,
    input  logic [$clog2(N)-1:0] raddr_b,
    output logic [W-1:0]         rdata_a,
    output logic [W-1:0]         rdata_b
);
    localparam int AW = $clog2(N);

    logic [N-1:0][W-1:0] cells;

    for (genvar i = 0; i < N; i++) begin : g_cell
        logic hit;
        assign hit = we && (waddr == AW'(i));

        always_ff @(posedge clk) begin
            if (rst)      cells[i] <= '0;
            else if (hit) cells[i] <= wdata;
        end

        assert_cell_hold_R3: assert property (@(posedge clk) disable iff (rst)
            !(we && waddr == AW'(i)) |=> $stable(cells[i]));
        assert_cell_write_R3: assert property (@(posedge clk) disable iff (rst)
            we && waddr == AW'(i) |=> cells[i] == $past(wdata));
    end

    assign rdata_a = cells[raddr_a];
    assign rdata_b = cells[raddr_b];
endmodule

// File: rtl/dec_regs.sv
module dec_regs
    import dec_regs_pkg::*;
#(
    parameter int W = DATA_W,
    parameter int N = NUM_REGS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [STATE_W-1:0] state,
    input  logic [W-1:0]       mem_dout,
    input  logic [W-1:0]       wb_data,
    output logic [3*W-1:0]     data_bundle,
    output logic [1:0]         itype,
    output logic [2:0]         cond_flags
);
    logic        ir_load;
    logic        rf_we;
    logic [W-1:0] ir;
    reg_sel_t    sel;
    flags_t      flags;
    logic [W-1:0] opnd_a;
    logic [W-1:0] opnd_b;
    instr_cls_e  cls;

    assign ir_load = (state == ST_DECODE);
    assign rf_we   = (state == ST_REG_WRITE);

    dec_instr_reg #(.W(W)) u_ir (
        .clk  (clk),
        .rst  (rst),
        .load (ir_load),
        .din  (mem_dout),
        .ir   (ir),
        .sel  (sel)
    );

    dec_flag_reg #(.W(W)) u_flags (
        .clk   (clk),
        .rst   (rst),
        .upd   (rf_we),
        .val   (wb_data),
        .flags (flags)
    );

    dec_regfile #(.W(W), .N(N)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (rf_we),
        .waddr   (sel.dst),
        .wdata   (wb_data),
        .raddr_a (sel.src_a),
        .raddr_b (sel.src_b),
        .rdata_a (opnd_a),
        .rdata_b (opnd_b)
    );

    assign cls         = classify(mem_dout[W-1:W-4]);
    assign itype       = cls;
    assign data_bundle = {ir, opnd_a, opnd_b};
    assign cond_flags  = flags;

    assert_bundle_ir_R4: assert property (@(posedge clk) disable iff (rst)
        ir_load |=> data_bundle[3*W-1:2*W] == $past(mem_dout));
    assert_same_reg_old_R7: assert property (@(posedge clk) disable iff (rst)
        rf_we && (sel.dst == sel.src_a) && $stable(ir)
        |=> $past(data_bundle[2*W-1:W]) != data_bundle[2*W-1:W] || $past(wb_data) == data_bundle[2*W-1:W]);
    assert_reset_flags_R8: assert property (@(posedge clk)
        rst |=> cond_flags == 3'b010);
endmodule

// File: tb/tb_dec_regs.sv
`timescale 1ns/1ps
module tb_dec_regs;
    localparam logic [3:0] S_IDLE = 4'h0;
    localparam logic [3:0] S_DEC  = 4'h1;
    localparam logic [3:0] S_OTH  = 4'h5;
    localparam logic [3:0] S_WB   = 4'h8;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  state;
    logic [15:0] mem_dout, wb_data;
    logic [47:0] data_bundle;
    logic [1:0]  itype;
    logic [2:0]  cond_flags;

    int n_cmp = 0;
    int n_bad = 0;

    logic [15:0] m_ir;
    logic [15:0] m_rf [8];
    logic [2:0]  m_cc;

    always #10 clk = ~clk;

    dec_regs dut (
        .clk(clk), .rst(rst), .state(state), .mem_dout(mem_dout),
        .wb_data(wb_data), .data_bundle(data_bundle), .itype(itype),
        .cond_flags(cond_flags)
    );

    task automatic chk(input string req, input string what, input logic [47:0] act, input logic [47:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [2:0] m_sr2(input logic [15:0] i);
        if (i[15:12] == 4'b0011 || i[15:12] == 4'b0111 || i[15:12] == 4'b1011) return i[11:9];
        return i[2:0];
    endfunction

    function automatic logic [47:0] m_bundle();
        return {m_ir, m_rf[m_ir[8:6]], m_rf[m_sr2(m_ir)]};
    endfunction

    function automatic logic [2:0] m_flags(input logic [15:0] v);
        if (v == 16'h0) return 3'b010;
        if (v[15])      return 3'b100;
        return 3'b001;
    endfunction

    function automatic logic [1:0] m_cls(input logic [3:0] op);
        case (op)
            4'b0001, 4'b0101, 4'b1001: return 2'd0;
            4'b0000, 4'b1100, 4'b0100: return 2'd1;
            4'b1000, 4'b1101, 4'b1111: return 2'd3;
            default:                   return 2'd2;
        endcase
    endfunction

    function automatic logic [15:0] add_op(input int d, input int a, input int b);
        return {4'b0001, 3'(d), 3'(a), 3'b000, 3'(b)};
    endfunction

    task automatic cyc(input logic [3:0] st, input logic [15:0] md, input logic [15:0] wb);
        @(negedge clk);
        state = st; mem_dout = md; wb_data = wb;
        @(posedge clk);
        if (st == S_DEC) m_ir = md;
        if (st == S_WB) begin
            m_rf[m_ir[11:9]] = wb;
            m_cc = m_flags(wb);
        end
        #5;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; state = S_IDLE; mem_dout = 16'h0; wb_data = 16'h0;
        @(posedge clk); @(posedge clk);
        #5;
        m_ir = 16'h0; m_cc = 3'b010;
        for (int i = 0; i < 8; i++) m_rf[i] = 16'h0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic write_reg(input int r, input logic [15:0] v);
        cyc(S_DEC, add_op(r, 0, 0), 16'h0);
        cyc(S_WB, 16'h0, v);
    endtask

    task automatic t_reset();
        chk("R8", "bundle after reset", data_bundle, 48'h0);
        chk("R8", "flags after reset", {45'h0, cond_flags}, {45'h0, 3'b010});
    endtask

    task automatic t_ir_load();
        cyc(S_DEC, 16'h1A47, 16'h0);
        chk("R1", "ir after decode", {32'h0, data_bundle[47:32]}, {32'h0, 16'h1A47});
        cyc(S_OTH, 16'hBEEF, 16'h0);
        chk("R1", "ir held outside decode", {32'h0, data_bundle[47:32]}, {32'h0, m_ir});
        cyc(S_WB, 16'h5555, 16'h0042);
        chk("R1", "ir held in update", {32'h0, data_bundle[47:32]}, {32'h0, 16'h1A47});
    endtask

    task automatic t_itype();
        for (int op = 0; op < 16; op++) begin
            @(negedge clk);
            state = (op % 2 == 0) ? S_DEC : S_OTH;
            mem_dout = {4'(op), 12'h5C3};
            #1;
            chk("R2", $sformatf("class of opcode %0d", op), {46'h0, itype}, {46'h0, m_cls(4'(op))});
            @(posedge clk);
            if (state == S_DEC) m_ir = mem_dout;
        end
    endtask

    task automatic t_write_read();
        for (int r = 0; r < 8; r++) write_reg(r, 16'h1100 + 16'(r * 16'h0111));
        for (int r = 0; r < 8; r++) begin
            cyc(S_DEC, add_op(0, r, 7 - r), 16'h0);
            chk("R4", $sformatf("bundle read %0d/%0d", r, 7 - r), data_bundle, m_bundle());
            chk("R3", $sformatf("reg %0d content", r), {32'h0, data_bundle[31:16]}, {32'h0, 16'h1100 + 16'(r * 16'h0111)});
        end
    endtask

    task automatic t_blocked_write();
        cyc(S_DEC, add_op(4, 4, 3), 16'h0);
        cyc(S_OTH, 16'h0, 16'hDEAD);
        cyc(S_IDLE, 16'h0, 16'h8001);
        chk("R9", "target reg unchanged outside update", data_bundle, m_bundle());
        chk("R9", "flags unchanged outside update", {45'h0, cond_flags}, {45'h0, m_cc});
    endtask

    task automatic t_flags();
        logic [15:0] vals [5] = '{16'h0000, 16'h8000, 16'h7FFF, 16'h0001, 16'hFFFF};
        for (int k = 0; k < 5; k++) begin
            write_reg(2, vals[k]);
            chk("R6", $sformatf("flags for %h", vals[k]), {45'h0, cond_flags}, {45'h0, m_flags(vals[k])});
        end
        cyc(S_DEC, add_op(2, 2, 2), 16'h0);
        chk("R6", "written value read back", data_bundle, m_bundle());
    endtask

    task automatic t_store_src();
        write_reg(5, 16'hC0DE);
        write_reg(1, 16'h0F0F);
        cyc(S_DEC, {4'b0011, 3'd5, 3'd2, 6'b000001}, 16'h0);
        chk("R5", "store takes sr2 from [11:9]", {32'h0, data_bundle[15:0]}, {32'h0, 16'hC0DE});
        cyc(S_DEC, {4'b0111, 3'd5, 3'd1, 6'b000001}, 16'h0);
        chk("R5", "indexed store sr2", data_bundle, m_bundle());
        cyc(S_DEC, {4'b0110, 3'd5, 3'd2, 6'b000001}, 16'h0);
        chk("R5", "load keeps sr2 from [2:0]", {32'h0, data_bundle[15:0]}, {32'h0, 16'h0F0F});
    endtask

    task automatic t_same_reg();
        logic [15:0] old;
        write_reg(3, 16'h2468);
        cyc(S_DEC, add_op(3, 3, 3), 16'h0);
        old = m_rf[3];
        @(negedge clk);
        state = S_WB; wb_data = 16'h9BDF;
        #1;
        chk("R7", "old value during write cycle", {32'h0, data_bundle[31:16]}, {32'h0, old});
        @(posedge clk);
        m_rf[3] = 16'h9BDF; m_cc = m_flags(16'h9BDF);
        #5;
        chk("R7", "new value after edge", data_bundle, m_bundle());
    endtask

    initial begin
        #(20 * 100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; state = S_IDLE; mem_dout = 16'h0; wb_data = 16'h0;
        do_reset();
        t_reset();
        t_ir_load();
        t_itype();
        t_write_read();
        t_blocked_write();
        t_flags();
        t_store_src();
        t_same_reg();
        do_reset();
        t_reset();
        cyc(S_DEC, add_op(0, 6, 7), 16'h0);
        chk("R8", "regs cleared by reset", data_bundle, m_bundle());
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule